// File: doc/BRIEF.md
# Approximate 8x8 Unsigned Multiplier with Selectable Summation Adders

This block multiplies two unsigned 8-bit operands and returns a 16-bit product. Each operand is split into a high nibble and a low nibble. Four 4x4 sub-multipliers form the nibble products. Each sub-multiplier reduces its partial-product rows in carry-save stages until two rows remain, then adds those two rows. The four results are weighted by their nibble positions. Three 16-bit adders combine them in a two-level tree.

A build parameter picks one adder style for all three adders. The first style is an exact ripple-carry adder. The second is a dual-carry approximate adder without correction. Its lower half drops carries inside the cells, and only a predicted carry crosses into the upper half. The third is the same approximate adder with a correction that fills the low bits when the carry crossing the split was lost. Optional input and output register stages help timing closure. With the defaults, both stages are present and the latency is two cycles.

Top module: `apx_mul`

## Requirements
- R1: With the exact adder style, `prod_o` equals `a_i * b_i` for all 65536 operand pairs.
- R2: The four sub-products are hi(a)·hi(b) shifted left 8, hi(a)·lo(b) shifted left 4, lo(a)·hi(b) shifted left 4, and lo(a)·lo(b) unshifted. Each sub-product is an exact 4x4 product.
- R3: The left adder sums the two sub-products that use hi(a). The right adder sums the two that use lo(a). The final adder sums the left and right results.
- R4: In both approximate styles, for adder bits 0 through 6, each sum bit is x^y^cin, and the carry into the next bit is x&y, with the incoming carry ignored.
- R5: In both approximate styles, bit 7 gives sum x^y^cin, an exact carry maj(x,y,cin), and a predicted carry x&y. Bit 8 forms its sum from the exact carry. Bit 8 forms its outgoing carry from the predicted carry.
- R6: In every style, bits 9 through 15 ripple exactly. Any carry out of bit 15 is discarded.
- R7: In the corrected style, bits 8 down to 0 of an adder output are all forced to 1 when three conditions hold together: the exact carry out of bit 7 is 1, the predicted carry is 0, and x[8]^y[8] is 1.
- R8: The product appears IN_REG+OUT_REG rising edges after the operands are sampled. With the defaults this is 2.
- R9: While `rst_n` is low, the registered operands and the registered product are zero, so `prod_o` is zero.
- R10: In every style, each adder output is never greater than the exact sum of its inputs. As a result, the product never exceeds `a_i * b_i`, and a zero operand always gives a zero product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional register stages |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | 8 | Multiplicand, unsigned |
| b_i | input | 8 | Multiplier, unsigned |
| prod_o | output | 16 | Product, exact or approximate depending on the adder style |

## Verification
With the default registers, a product is due two rising edges after its operands are applied, and one edge after they are applied the output still shows the previous product. The bench changes operands on falling edges. It keeps a two-entry queue of expected values, so each comparison on a falling edge uses the operands driven two falling edges earlier. A directed sequence then checks that the new product has not arrived one edge in and has arrived two edges in. The three adder sums inside the block are combinational on the registered operands and are checked in the same cycle those operands are held.

// File: rtl/apx_mul_pkg.sv
package apx_mul_pkg;

    // Adder style used by all three summation adders
    typedef enum logic [1:0] {
        SUM_EXACT    = 2'd0,
        SUM_DUAL_RAW = 2'd1,
        SUM_DUAL_FIX = 2'd2
    } sum_kind_e;

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/nib_wallace_mul.sv
module nib_wallace_mul #(
    parameter int NB = 4
) (
    input  logic [NB-1:0]   x,
    input  logic [NB-1:0]   y,
    output logic [2*NB-1:0] p
);
    localparam int RW = 2 * NB;
    localparam int ST = NB - 1;

    logic [RW-1:0] row   [NB];
    logic [RW-1:0] s_st  [ST];
    logic [RW-1:0] c_st  [ST];

    // partial-product rows, weighted by the multiplier bit position
    for (genvar j = 0; j < NB; j++) begin : g_row
        assign row[j] = RW'(x & {NB{y[j]}}) << j;
    end

    // carry-save reduction: each stage folds one more row into two
    assign s_st[0] = row[0];
    assign c_st[0] = row[1];
    for (genvar k = 1; k < ST; k++) begin : g_csa
        assign s_st[k] = s_st[k-1] ^ c_st[k-1] ^ row[k+1];
        assign c_st[k] = ((s_st[k-1] & c_st[k-1]) |
                          (s_st[k-1] & row[k+1])  |
                          (c_st[k-1] & row[k+1])) << 1;
    end

    // final two-row ripple addition
    always_comb begin : fin_add
        logic cy;
        cy = 1'b0;
        for (int i = 0; i < RW; i++) begin
            p[i] = s_st[ST-1][i] ^ c_st[ST-1][i] ^ cy;
            cy   = apx_mul_pkg::maj3(s_st[ST-1][i], c_st[ST-1][i], cy);
        end
    end

endmodule

// File: rtl/sum_adder.sv
module sum_adder
    import apx_mul_pkg::*;
#(
    parameter int        W     = 16,
    parameter int        SPLIT = 8,
    parameter sum_kind_e KIND  = SUM_EXACT
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s
);
    localparam bit DUAL = (KIND != SUM_EXACT);
    localparam bit FILL = (KIND == SUM_DUAL_FIX);

    always_comb begin : add_b
        logic         cy;
        logic         c_ex;
        logic         c_pr;
        logic         fill_en;
        logic [W-1:0] r;
        cy   = 1'b0;
        c_ex = 1'b0;
        c_pr = 1'b0;
        r    = '0;
        for (int i = 0; i < W; i++) begin
            r[i] = x[i] ^ y[i] ^ cy;
            if (!DUAL || i > SPLIT) begin
                cy = maj3(x[i], y[i], cy);
            end else if (i < SPLIT - 1) begin
                cy = x[i] & y[i];
            end else if (i == SPLIT - 1) begin
                c_ex = maj3(x[i], y[i], cy);
                c_pr = x[i] & y[i];
                cy   = c_ex;
            end else begin
                cy = maj3(x[i], y[i], c_pr);
            end
        end
        fill_en = FILL && c_ex && !c_pr && (x[SPLIT] ^ y[SPLIT]);
        if (fill_en) begin
            r[SPLIT:0] = '1;
        end
        s = r;
    end

endmodule

// File: rtl/apx_mul.sv
module apx_mul
    import apx_mul_pkg::*;
#(
    parameter int        OPW     = 8,
    parameter sum_kind_e KIND    = SUM_EXACT,
    parameter bit        IN_REG  = 1'b1,
    parameter bit        OUT_REG = 1'b1,
    parameter int        SPLIT   = OPW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPW-1:0]   a_i,
    input  logic [OPW-1:0]   b_i,
    output logic [2*OPW-1:0] prod_o
);
    localparam int NB = OPW / 2;
    localparam int PW = 2 * OPW;

    typedef struct packed {
        logic [OPW-1:0] a;
        logic [OPW-1:0] b;
        logic [PW-1:0]  p;
    } stage_t;

    stage_t st_d, st_q;

    logic [OPW-1:0] op_a, op_b;
    logic [OPW-1:0] sp   [4];
    logic [PW-1:0]  sh   [4];
    logic [PW-1:0]  lx, ly, rx, ry;
    logic [PW-1:0]  lsum, rsum, fsum;

    assign op_a = IN_REG ? st_q.a : a_i;
    assign op_b = IN_REG ? st_q.b : b_i;

    // g = 2*sel_a_hi + sel_b_hi ; weight = NB * (sel_a_hi + sel_b_hi)
    for (genvar g = 0; g < 4; g++) begin : g_sub
        localparam bit AH = (g / 2) == 1;
        localparam bit BH = (g % 2) == 1;
        nib_wallace_mul #(.NB(NB)) u_nib (
            .x (AH ? op_a[OPW-1:NB] : op_a[NB-1:0]),
            .y (BH ? op_b[OPW-1:NB] : op_b[NB-1:0]),
            .p (sp[g])
        );
        assign sh[g] = PW'(sp[g]) << (NB * (int'(AH) + int'(BH)));
    end

    assign lx = sh[3];
    assign ly = sh[2];
    assign rx = sh[1];
    assign ry = sh[0];

    sum_adder #(.W(PW), .SPLIT(SPLIT), .KIND(KIND)) u_left  (.x(lx),   .y(ly),   .s(lsum));
    sum_adder #(.W(PW), .SPLIT(SPLIT), .KIND(KIND)) u_right (.x(rx),   .y(ry),   .s(rsum));
    sum_adder #(.W(PW), .SPLIT(SPLIT), .KIND(KIND)) u_final (.x(lsum), .y(rsum), .s(fsum));

    always_comb begin
        st_d.a = a_i;
        st_d.b = b_i;
        st_d.p = fsum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prod_o = OUT_REG ? st_q.p : fsum;

endmodule

// File: rtl/apx_mul_chk.sv
module apx_mul_chk
    import apx_mul_pkg::*;
#(
    parameter int        OPW  = 8,
    parameter sum_kind_e KIND = SUM_EXACT,
    parameter int        LAT  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OPW-1:0]   a_i,
    input logic [OPW-1:0]   b_i,
    input logic [2*OPW-1:0] prod_o,
    input logic [OPW-1:0]   op_a,
    input logic [OPW-1:0]   op_b,
    input logic [2*OPW-1:0] lx,
    input logic [2*OPW-1:0] ly,
    input logic [2*OPW-1:0] lsum,
    input logic [2*OPW-1:0] rx,
    input logic [2*OPW-1:0] ry,
    input logic [2*OPW-1:0] rsum,
    input logic [2*OPW-1:0] fsum
);
    localparam int PW = 2 * OPW;

    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    if (KIND == SUM_EXACT) begin : g_exact
        // R1
        exact_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fsum == PW'(op_a) * PW'(op_b));
    end

    // R10
    left_no_excess_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, lsum} <= {1'b0, lx} + {1'b0, ly});
    // R10
    right_no_excess_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, rsum} <= {1'b0, rx} + {1'b0, ry});
    // R10
    final_no_excess_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, fsum} <= {1'b0, lsum} + {1'b0, rsum});

    if (LAT == 2) begin : g_lat2
        if (KIND == SUM_EXACT) begin : g_lat_exact
            // R8
            latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst >= 2'd2) |->
                (prod_o == PW'($past(a_i, 2)) * PW'($past(b_i, 2))));
        end
        // R10
        zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 2'd2 && ($past(a_i, 2) == '0 || $past(b_i, 2) == '0))
            |-> (prod_o == '0));
    end

endmodule

bind apx_mul apx_mul_chk #(
    .OPW  (OPW),
    .KIND (KIND),
    .LAT  (int'(IN_REG) + int'(OUT_REG))
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod_o),
    .op_a   (op_a),
    .op_b   (op_b),
    .lx     (lx),
    .ly     (ly),
    .lsum   (lsum),
    .rx     (rx),
    .ry     (ry),
    .rsum   (rsum),
    .fsum   (fsum)
);

// File: tb/test_apx_mul.sv
module test_apx_mul;
    import apx_mul_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  a = '0, b = '0;
    logic [15:0] pe, pr, pm;

    int errs = 0;
    int checks = 0;

    always #5 clk = ~clk;

    apx_mul #(.KIND(SUM_EXACT))    i_apx_mul     (.clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .prod_o(pe));
    apx_mul #(.KIND(SUM_DUAL_RAW)) i_apx_mul_raw (.clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .prod_o(pr));
    apx_mul #(.KIND(SUM_DUAL_FIX)) i_apx_mul_fix (.clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .prod_o(pm));

    // kind: 0 exact, 1 dual raw, 2 dual with fill (R4 R5 R6 R7)
    function automatic logic [15:0] model_add(logic [15:0] x, logic [15:0] y, int kind);
        logic [15:0] r;
        logic c, cex, cpr;
        c = 1'b0; cex = 1'b0; cpr = 1'b0;
        for (int i = 0; i < 16; i++) begin
            r[i] = x[i] ^ y[i] ^ c;
            if (kind == 0 || i > 8)  c = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
            else if (i < 7)          c = x[i] & y[i];
            else if (i == 7) begin
                cex = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
                cpr = x[i] & y[i];
                c   = cex;
            end else                 c = (x[i] & y[i]) | (cpr & (x[i] ^ y[i]));
        end
        if (kind == 2 && cex && !cpr && (x[8] ^ y[8])) r[8:0] = '1;
        return r;
    endfunction

    // R2 R3: nibble products, weights and tree pairing
    function automatic logic [15:0] model_mul(logic [7:0] x, logic [7:0] y, int kind);
        logic [15:0] hh, hl, lh, ll;
        hh = 16'(x[7:4] * y[7:4]) << 8;
        hl = 16'(x[7:4] * y[3:0]) << 4;
        lh = 16'(x[3:0] * y[7:4]) << 4;
        ll = 16'(x[3:0] * y[3:0]);
        return model_add(model_add(hh, hl, kind), model_add(lh, ll, kind), kind);
    endfunction

    task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag,
                       input logic [7:0] x, input logic [7:0] y);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s a=%h b=%h actual=%h expected=%h", tag, x, y, got, exp);
        end
    endtask

    task automatic chk_le(input logic [15:0] got, input logic [15:0] lim, input string tag,
                          input logic [7:0] x, input logic [7:0] y);
        checks++;
        if (got > lim) begin
            errs++;
            $display("FAIL %s a=%h b=%h actual=%h expected<=%h", tag, x, y, got, lim);
        end
    endtask

    logic [7:0] qa [2];
    logic [7:0] qb [2];
    logic       qv [2];

    // drive on a falling edge, compare the vector from two falling edges back (R8)
    task automatic step(input logic [7:0] na, input logic [7:0] nb, input logic nv);
        @(negedge clk);
        if (qv[1]) begin
            chk(pe, qa[1] * qb[1], "R1/R2", qa[1], qb[1]);
            chk(pr, model_mul(qa[1], qb[1], 1), "R3/R4/R5/R6", qa[1], qb[1]);
            chk(pm, model_mul(qa[1], qb[1], 2), "R3/R7", qa[1], qb[1]);
            chk_le(pr, qa[1] * qb[1], "R10", qa[1], qb[1]);
            chk_le(pm, qa[1] * qb[1], "R10", qa[1], qb[1]);
            if (qa[1] == 0 || qb[1] == 0) begin
                chk(pr, 16'h0, "R10", qa[1], qb[1]);
                chk(pm, 16'h0, "R10", qa[1], qb[1]);
            end
        end
        qa[1] = qa[0]; qb[1] = qb[0]; qv[1] = qv[0];
        qa[0] = na;    qb[0] = nb;    qv[0] = nv;
        a = na;
        b = nb;
    endtask

    function automatic logic [7:0] pick(int r);
        case (r % 6)
            0: return 8'hFF;
            1: return 8'h00;
            2: return {4'hF, 4'($urandom)};
            3: return {4'($urandom), 4'hF};
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        qv[0] = 1'b0; qv[1] = 1'b0;
        qa[0] = '0; qa[1] = '0; qb[0] = '0; qb[1] = '0;
        a = 8'hA5; b = 8'h5A;
        repeat (3) @(negedge clk);
        // R9
        chk(pe, 16'h0, "R9", a, b);
        chk(pr, 16'h0, "R9", a, b);
        chk(pm, 16'h0, "R9", a, b);
        rst_n = 1'b1;

        // exhaustive sweep
        for (int i = 0; i < 65536; i++) step(8'(i >> 8), 8'(i), 1'b1);

        // directed corners: all-ones nibbles, lower-half saturation (R5 R7)
        step(8'hFF, 8'hFF, 1'b1);
        step(8'h0F, 8'hF0, 1'b1);
        step(8'hF0, 8'h0F, 1'b1);
        step(8'h11, 8'hEF, 1'b1);
        step(8'h80, 8'h01, 1'b1);

        // biased random
        for (int n = 0; n < 3000; n++) step(pick(int'($urandom)), pick(int'($urandom)), 1'b1);

        // flush to zero products
        repeat (3) step(8'h00, 8'h00, 1'b0);

        // R8: one edge in the old product holds, two edges in the new one shows
        @(negedge clk);
        a = 8'hFF; b = 8'hFF;
        @(negedge clk);
        chk(pe, 16'h0000, "R8", a, b);
        @(negedge clk);
        chk(pe, 16'hFE01, "R8", a, b);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule